// File: doc/BRIEF.md
# Last-Value Load Predictor

This block guesses the word a load instruction will return by remembering what that same load returned the previous time. A fetch or decode stage presents the load's instruction address on the lookup port. In the same cycle the block answers with three things: whether the table knows that load, whether it is confident enough to predict, and the remembered value.

When the load later resolves, the pipeline presents the load's address, the word actually read, and whether a prediction had been handed out. The block then trains itself. A known load whose remembered word was right gains confidence. A known load whose remembered word was wrong loses confidence and takes the new word. An unknown load claims its slot. Squashing, value comparison in the pipeline and recovery are handled elsewhere.

The table is direct-mapped. Each slot holds a valid flag, an address tag, the last word and a 2-bit saturating confidence count. A prediction is offered only once the count reaches 2.

Top module: `ldval_predictor`

## Requirements
- R1: When the lookup hits, `lk_value` equals the last word stored for that slot. When it misses, `lk_value` is zero.
- R2: The table has 16 slots selected by PC bits [5:2], with PC bits [31:6] kept as the tag. A lookup hits only if the slot is valid and its tag equals the tag of the looked-up PC. PC bits [1:0] have no effect.
- R3: `lk_predict` is high only when the lookup hits and the slot's confidence is 2 or 3.
- R4: An update that hits and carries a word equal to the stored word raises the confidence by one, saturating at 3. The stored word is unchanged.
- R5: An update that hits and carries a different word lowers the confidence by one, saturating at 0, and replaces the stored word with the new one.
- R6: An update that misses with `up_predicted` low makes the slot valid with the new tag and word, and sets its confidence to 0.
- R7: An update that misses with `up_predicted` high leaves the table unchanged.
- R8: After reset every slot is invalid, so every lookup misses.
- R9: A lookup in the same cycle as an update to the same slot returns the contents from before that update. The new contents appear to lookups from the next cycle.
- R10: While `up_valid` is low, the address and data on the update port change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | 32 | Address of the load being looked up |
| lk_hit | output | 1 | The load is present in the table |
| lk_predict | output | 1 | The prediction may be used (hit and confidence at least 2) |
| lk_value | output | 32 | Predicted word, zero on a miss |
| up_valid | input | 1 | A resolved load is presented for training |
| up_pc | input | 32 | Address of the resolved load |
| up_value | input | 32 | Word the resolved load actually returned |
| up_predicted | input | 1 | A prediction was handed out for this load |

## Verification
Lookup and training can fall in the same cycle on the same slot. The bench makes this happen on every training step by putting the same address on both ports in one cycle. It checks that the answer reflects the slot before the edge, and then reads the trained slot with a lookup on the following cycle. Each of the 16 slots in turn is walked through allocation, confidence rising to saturation, repeated wrong words driving the count to zero, an aliasing address that is dropped while flagged as predicted, and finally eviction. Expected answers come from a small arithmetic table model in the bench.

// File: rtl/ldval_pkg.sv
package ldval_pkg;

  // Training action chosen for the slot addressed by the update port.
  typedef enum logic [1:0] {
    ACT_IDLE     = 2'd0,
    ACT_ALLOC    = 2'd1,
    ACT_TRAIN_UP = 2'd2,
    ACT_TRAIN_DN = 2'd3
  } upd_act_e;

  // Byte-offset bits below the word index.
  localparam int unsigned WORD_OFS_W = 2;

endpackage

// File: rtl/ldval_rst_sync.sv
module ldval_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ldval_pc_split.sv
module ldval_pc_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned OFS_W = 2,
  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];

endmodule

// File: rtl/ldval_conf_step.sv
module ldval_conf_step #(
  parameter int unsigned CONF_W = 2
) (
  input  logic [CONF_W-1:0] conf_in,
  input  logic              go_up,
  output logic [CONF_W-1:0] conf_out
);

  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_MIN = '0;

  always_comb begin
    conf_out = conf_in;
    if (go_up) begin
      if (conf_in != CONF_MAX) begin
        conf_out = conf_in + 1'b1;
      end
    end else begin
      if (conf_in != CONF_MIN) begin
        conf_out = conf_in - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ldval_entry.sv
module ldval_entry #(
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [DATA_W-1:0] value_in,
  input  logic [CONF_W-1:0] conf_in,
  output logic              valid_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] value_q,
  output logic [CONF_W-1:0] conf_q
);

  logic              valid_d;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] value_d;
  logic [CONF_W-1:0] conf_d;

  // Next-state with explicit clock enable.
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    value_d = value_q;
    conf_d  = conf_q;
    if (wr_en) begin
      valid_d = 1'b1;
      tag_d   = tag_in;
      value_d = value_in;
      conf_d  = conf_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      value_q <= '0;
      conf_q  <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      value_q <= value_d;
      conf_q  <= conf_d;
    end
  end

endmodule

// File: rtl/ldval_predictor.sv
module ldval_predictor #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ENTRIES     = 16,
  parameter int unsigned CONF_W      = 2,
  parameter int unsigned PRED_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic              lk_predict,
  output logic [DATA_W-1:0] lk_value,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [DATA_W-1:0] up_value,
  input  logic              up_predicted
);

  import ldval_pkg::*;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned OFS_W = WORD_OFS_W;
  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [CONF_W-1:0] THRESH = PRED_THRESH[CONF_W-1:0];

  logic rst_sync_n;

  ldval_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  // Table state.
  logic              ent_valid [ENTRIES];
  logic [TAG_W-1:0]  ent_tag   [ENTRIES];
  logic [DATA_W-1:0] ent_value [ENTRIES];
  logic [CONF_W-1:0] ent_conf  [ENTRIES];

  // Address split for both ports.
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] up_tag;

  ldval_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_lk_split (
    .pc  (lk_pc),
    .idx (lk_idx),
    .tag (lk_tag)
  );

  ldval_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_up_split (
    .pc  (up_pc),
    .idx (up_idx),
    .tag (up_tag)
  );

  // Lookup port: reads the registered table, so a same-cycle update is not seen.
  logic lk_match;

  always_comb begin
    lk_match   = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_tag);
    lk_hit     = lk_match;
    lk_predict = lk_match && (ent_conf[lk_idx] >= THRESH);
    lk_value   = lk_match ? ent_value[lk_idx] : '0;
  end

  // Update port: decide the training action.
  logic              up_hit;
  logic              up_same;
  logic [CONF_W-1:0] conf_stepped;
  upd_act_e          up_act;
  logic [CONF_W-1:0] conf_wr;

  always_comb begin
    up_hit  = ent_valid[up_idx] && (ent_tag[up_idx] == up_tag);
    up_same = (ent_value[up_idx] == up_value);
  end

  ldval_conf_step #(.CONF_W(CONF_W)) u_conf_step (
    .conf_in  (ent_conf[up_idx]),
    .go_up    (up_same),
    .conf_out (conf_stepped)
  );

  always_comb begin
    up_act = ACT_IDLE;
    if (up_valid) begin
      if (up_hit) begin
        up_act = up_same ? ACT_TRAIN_UP : ACT_TRAIN_DN;
      end else if (!up_predicted) begin
        up_act = ACT_ALLOC;
      end
    end
    conf_wr = (up_act == ACT_ALLOC) ? '0 : conf_stepped;
  end

  // Slot storage, one instance per slot.
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = (up_act != ACT_IDLE) && (up_idx == IDX_W'(gi));

    ldval_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (slot_we),
      .tag_in   (up_tag),
      .value_in (up_value),
      .conf_in  (conf_wr),
      .valid_q  (ent_valid[gi]),
      .tag_q    (ent_tag[gi]),
      .value_q  (ent_value[gi]),
      .conf_q   (ent_conf[gi])
    );
  end

  // Flattened views for the bound checker.
  logic [ENTRIES-1:0]        valid_vec;
  logic [ENTRIES*CONF_W-1:0] conf_vec;

  for (genvar gv = 0; gv < ENTRIES; gv++) begin : g_flat
    assign valid_vec[gv]                 = ent_valid[gv];
    assign conf_vec[gv*CONF_W +: CONF_W] = ent_conf[gv];
  end

endmodule

// File: rtl/ldval_predictor_chk.sv
module ldval_predictor_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned CONF_W  = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_hit,
  input logic                      lk_predict,
  input logic                      up_valid,
  input logic                      up_predicted,
  input logic                      up_hit,
  input logic                      up_same,
  input logic [IDX_W-1:0]          up_idx,
  input logic [ENTRIES-1:0]        valid_vec,
  input logic [ENTRIES*CONF_W-1:0] conf_vec
);

  localparam logic [CONF_W-1:0] CMAX = '1;

  function automatic logic [CONF_W-1:0] conf_at(
    input logic [ENTRIES*CONF_W-1:0] v,
    input logic [IDX_W-1:0] i
  );
    return v[i*CONF_W +: CONF_W];
  endfunction

  function automatic logic [CONF_W-1:0] sat_inc(input logic [CONF_W-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CONF_W-1:0] sat_dec(input logic [CONF_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  assert_predict_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_predict |-> lk_hit);

  assert_conf_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_hit && up_same) |=>
      conf_at(conf_vec, $past(up_idx)) == sat_inc($past(conf_at(conf_vec, up_idx))));

  assert_conf_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_hit && !up_same) |=>
      conf_at(conf_vec, $past(up_idx)) == sat_dec($past(conf_at(conf_vec, up_idx))));

  assert_alloc_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_hit && !up_predicted) |=>
      (valid_vec[$past(up_idx)] && conf_at(conf_vec, $past(up_idx)) == '0));

  assert_stale_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_hit && up_predicted) |=> ($stable(valid_vec) && $stable(conf_vec)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> ($stable(valid_vec) && $stable(conf_vec)));

endmodule

bind ldval_predictor ldval_predictor_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W),
  .CONF_W  (CONF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .lk_hit       (lk_hit),
  .lk_predict   (lk_predict),
  .up_valid     (up_valid),
  .up_predicted (up_predicted),
  .up_hit       (up_hit),
  .up_same      (up_same),
  .up_idx       (up_idx),
  .valid_vec    (valid_vec),
  .conf_vec     (conf_vec)
);

// File: tb/ldval_predictor_bench.sv
module ldval_predictor_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit;
  logic        lk_predict;
  logic [31:0] lk_value;
  logic        up_valid;
  logic [31:0] up_pc;
  logic [31:0] up_value;
  logic        up_predicted;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference table built from the requirements.
  logic        ref_v [16];
  logic [25:0] ref_t [16];
  logic [31:0] ref_d [16];
  int          ref_c [16];

  ldval_predictor u_ldval_predictor (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_pc        (lk_pc),
    .lk_hit       (lk_hit),
    .lk_predict   (lk_predict),
    .lk_value     (lk_value),
    .up_valid     (up_valid),
    .up_pc        (up_pc),
    .up_value     (up_value),
    .up_predicted (up_predicted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string msg);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic ref_clear();
    for (int k = 0; k < 16; k++) begin
      ref_v[k] = 1'b0;
      ref_t[k] = '0;
      ref_d[k] = '0;
      ref_c[k] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    up_predicted = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ref_clear();
    repeat (4) @(negedge clk);
  endtask

  // One cycle: drive both ports, judge the lookup before the edge,
  // then apply the requirement rules to the reference table.
  task automatic cyc(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                     input logic [31:0] uval, input logic upr, input string tg);
    int li;
    int ui;
    logic eh;
    logic ep;
    logic [31:0] ev;
    logic uh;
    @(negedge clk);
    lk_pc = lpc;
    up_valid = uv;
    up_pc = upc;
    up_value = uval;
    up_predicted = upr;
    #1;
    li = int'(lpc[5:2]);
    eh = ref_v[li] && (ref_t[li] == lpc[31:6]);
    ep = eh && (ref_c[li] >= 2);
    ev = eh ? ref_d[li] : 32'h0;
    chk({31'b0, lk_hit}, {31'b0, eh}, {tg, " R2 hit"});
    chk({31'b0, lk_predict}, {31'b0, ep}, {tg, " R3 predict"});
    chk(lk_value, ev, {tg, " R1 value"});
    @(posedge clk);
    if (uv) begin
      ui = int'(upc[5:2]);
      uh = ref_v[ui] && (ref_t[ui] == upc[31:6]);
      if (uh) begin
        if (ref_d[ui] == uval) begin
          if (ref_c[ui] < 3) ref_c[ui] = ref_c[ui] + 1;
        end else begin
          if (ref_c[ui] > 0) ref_c[ui] = ref_c[ui] - 1;
          ref_d[ui] = uval;
        end
      end else if (!upr) begin
        ref_v[ui] = 1'b1;
        ref_t[ui] = upc[31:6];
        ref_d[ui] = uval;
        ref_c[ui] = 0;
      end
    end
  endtask

  task automatic sweep_empty(input string tg);
    for (int k = 0; k < 16; k++) begin
      cyc({26'h3A5 + 26'(k), 4'(k), 2'b00}, 1'b0, 32'h0, 32'h0, 1'b0, tg);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    lk_pc = '0;
    up_valid = 1'b0;
    up_pc = '0;
    up_value = '0;
    up_predicted = 1'b0;
    ref_clear();
    do_reset();

    sweep_empty("R8 reset");

    for (int i = 0; i < 16; i++) begin
      logic [25:0] ta;
      logic [31:0] pa;
      logic [31:0] pa_off;
      logic [31:0] pb;
      logic [31:0] v0;
      ta = 26'(i * 7 + 1);
      pa = {ta, 4'(i), 2'b00};
      pa_off = {ta, 4'(i), 2'(i)};
      pb = {ta ^ 26'h155, 4'(i), 2'b00};
      v0 = 32'hA000_0000 + 32'(i) * 32'h111;
      // R6 allocate; the same-cycle lookup sees the empty slot (R9).
      cyc(pa, 1'b1, pa, v0, 1'b0, "R6 alloc R9");
      // R4 confidence climbs 1,2,3 and saturates.
      for (int r = 0; r < 4; r++) cyc(pa, 1'b1, pa, v0, 1'b0, "R4 up R9");
      // R10 idle cycle with junk on the update port.
      cyc(pa_off, 1'b0, pa, 32'hDEAD_BEEF, 1'b0, "R10 idle R2 offset");
      // R5 wrong word: count drops, word replaced.
      cyc(pa, 1'b1, pa, v0 ^ 32'h1, 1'b1, "R5 down R9");
      // R7 aliasing address flagged as predicted is dropped.
      cyc(pb, 1'b1, pb, 32'h5, 1'b1, "R7 drop");
      cyc(pa, 1'b0, pb, 32'h6, 1'b0, "R7 check R10");
      // R5 repeated wrong words reach and hold at zero.
      for (int r = 0; r < 4; r++) cyc(pa, 1'b1, pa, v0 + 32'(r) + 32'h10, 1'b0, "R5 floor");
      cyc(pa, 1'b0, pa, 32'h0, 1'b0, "R5 check");
      // R6 eviction by the aliasing address.
      cyc(pb, 1'b1, pb, 32'h77, 1'b0, "R6 evict");
      cyc(pa, 1'b0, pa, 32'h0, 1'b0, "R6 evicted");
      cyc(pb, 1'b0, pa, 32'h0, 1'b0, "R6 new owner");
    end

    // Every slot still holds its last owner before a second reset.
    for (int i = 0; i < 16; i++) begin
      cyc({26'(i * 7 + 1) ^ 26'h155, 4'(i), 2'b11}, 1'b0, 32'h0, 32'h0, 1'b0, "R2 final");
    end

    do_reset();
    sweep_empty("R8 rereset");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule